// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Min-Sum Decoder

This block decodes one codeword of a small regular quasi-cyclic LDPC code. The parity-check matrix is a grid of NR block-rows by NC block-columns, each block a P-by-P identity matrix rotated by a shift of (e_i * j) mod P, where j is the block-column and e_i the exponent of block-row i (1, 3 and 6 for the three default rows). The code word holds N = NC*P bits.

Channel log-likelihood ratios are shifted in one per cycle while the decoder is idle. A start pulse then runs iterative min-sum decoding. Each iteration is a bit-node phase and then a check-node phase. One bit engine per block-column and one check engine per block-row each step through their P nodes, one per cycle, and all engines of a kind run side by side. Messages pass through edge stores. Each check engine forms its edge addresses on the fly from the node counter and the circulant shift. Decoding ends when the parity checks are all met or when the iteration limit is reached. A one-cycle done pulse then reports the hard-decision word, a converged flag and the iteration count.

Top module: `ldpc_qc_decoder`

## Requirements
- R1: After reset, busy, done and converged are 0, iter_count is 0 and codeword is all zero.
- R2: While idle, each cycle with llr_valid high stores llr_in (4-bit two's complement) as the LLR of code bit n, with n = 0, 1, 2, ... in arrival order. Bit n sits in block-column n / P at position n mod P. An input of -8 is treated as -7.
- R3: Bit k of block-column j takes part in check (k + (e_i*j) mod P) mod P of block-row i, with e = 1, 3, 6 for rows 0, 1, 2.
- R4: In the bit phase, the total of a bit is its LLR plus all incoming check messages. Its hard decision (codeword bit n) is 1 when the total is negative and 0 when the total is zero or positive.
- R5: The bit-to-check message is the total minus that check's own message, clipped to -7..+7. The check-to-bit message has the smallest magnitude among the check's other incoming messages. Its sign is negative when an odd number of those others are negative, with zero counted as positive. Check messages start at zero.
- R6: When all checks are met by the hard decisions of an iteration, the decoder stops with converged = 1 and iter_count equal to the number of iterations run, counted from 1.
- R7: If the checks still fail after MAX_IT iterations, the decoder stops with converged = 0 and iter_count = MAX_IT.
- R8: Each iteration lasts 2*P cycles. done is a one-cycle pulse that comes 2*P*iter_count clock edges after the edge that samples start, and busy falls in the same cycle.
- R9: llr_valid and start have no effect while busy.
- R10: codeword, converged and iter_count hold their values from done until the next start, including while new LLRs are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| llr_valid | input | 1 | Loads llr_in into the next code-bit slot while idle |
| llr_in | input | MW | Channel LLR, two's complement |
| start | input | 1 | Begins decoding while idle |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle end-of-decode pulse |
| converged | output | 1 | All parity checks met at the end |
| iter_count | output | IW | Iterations used |
| codeword | output | N | Hard decisions, bit n = code bit n |

## Verification
The checker assumes that the caller never pulses start before a full set of N LLRs has been loaded. It also assumes that llr_in lies in the 4-bit range, so every run decodes a defined word. The bench always loads all N values before it pulses start. Its only out-of-phase traffic is the deliberate llr_valid and start pulses sent while busy, and R9 requires that the decoder ignores these. With that assumption, the checker computes the syndrome of the output word itself, using the circulant rule, and checks it against the converged flag at each done pulse.

// File: rtl/ldpc_pkg.sv
// Shared types and code-structure helpers for the QC-LDPC decoder.
// Assumes at most six block-rows (exponents repeat beyond that).
package ldpc_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_BIT, ST_CHK} dec_state_t;

    // Exponent of block-row i in the circulant exponent grid.
    function automatic int row_exp(input int i);
        case (i % 6)
            0:       return 1;
            1:       return 3;
            2:       return 6;
            3:       return 2;
            4:       return 4;
            default: return 5;
        endcase
    endfunction

    // Rotation of the circulant at block-row i, block-column j.
    function automatic int circ_shift(input int i, input int j, input int p);
        return (row_exp(i) * j) % p;
    endfunction

endpackage

// File: rtl/ldpc_bpe.sv
// Bit-processing element: combinational update of one bit node.
// Takes the channel LLR and NR incoming check messages; gives the clipped
// extrinsic messages back to each check and the hard decision.
// Assumes inputs are symmetric-range (no most-negative code).
module ldpc_bpe #(
    parameter int NR = 3,
    parameter int MW = 4,
    parameter int SW = MW + $clog2(NR + 1) + 1
) (
    input  logic [MW-1:0]    llr_in,
    input  logic [NR*MW-1:0] c2v_in,
    output logic [NR*MW-1:0] v2c_out,
    output logic             hard
);
    localparam int MAXM = (1 << (MW - 1)) - 1;
    localparam logic signed [SW-1:0] HI = SW'(MAXM);
    localparam logic signed [SW-1:0] LO = SW'(-MAXM);

    logic signed [SW-1:0] total;
    logic signed [SW-1:0] diff;

    // Sum channel value and all check messages, then form clipped extrinsics.
    always_comb begin
        total = SW'($signed(llr_in));
        for (int i = 0; i < NR; i++)
            total = total + SW'($signed(c2v_in[i*MW +: MW]));
        v2c_out = '0;
        diff    = '0;
        for (int i = 0; i < NR; i++) begin
            diff = total - SW'($signed(c2v_in[i*MW +: MW]));
            if (diff > HI)      v2c_out[i*MW +: MW] = HI[MW-1:0];
            else if (diff < LO) v2c_out[i*MW +: MW] = LO[MW-1:0];
            else                v2c_out[i*MW +: MW] = diff[MW-1:0];
        end
        hard = total[SW-1];
    end

endmodule

// File: rtl/ldpc_cpe.sv
// Check-processing element: combinational min-sum update of one check node.
// Gives each of NC neighbours the min magnitude and sign product of the
// others, plus the parity of the neighbours' hard decisions.
// Assumes messages never hold the most-negative code.
module ldpc_cpe #(
    parameter int NC = 5,
    parameter int MW = 4
) (
    input  logic [NC*MW-1:0] v2c_in,
    input  logic [NC-1:0]    hard_in,
    output logic [NC*MW-1:0] c2v_out,
    output logic             parity
);
    localparam int IXW = (NC > 1) ? $clog2(NC) : 1;

    logic [MW-1:0]  mag [NC];
    logic [NC-1:0]  sgn;
    logic [MW-1:0]  min1, min2, v, mo;
    logic [IXW-1:0] min_idx;
    logic           stot, so;

    // Find the two smallest magnitudes and the overall sign.
    always_comb begin
        min1 = '1; min2 = '1; min_idx = '0; stot = 1'b0; v = '0;
        for (int j = 0; j < NC; j++) begin
            v      = v2c_in[j*MW +: MW];
            sgn[j] = v[MW-1];
            mag[j] = v[MW-1] ? (~v + 1'b1) : v;
            stot   = stot ^ v[MW-1];
            if (mag[j] < min1) begin
                min2 = min1; min1 = mag[j]; min_idx = IXW'(j);
            end else if (mag[j] < min2) begin
                min2 = mag[j];
            end
        end
    end

    // Build each outgoing message, excluding the receiver's own input.
    always_comb begin
        c2v_out = '0; mo = '0; so = 1'b0;
        for (int j = 0; j < NC; j++) begin
            mo = (min_idx == IXW'(j)) ? min2 : min1;
            so = stot ^ sgn[j];
            c2v_out[j*MW +: MW] = so ? (~mo + 1'b1) : mo;
        end
        parity = ^hard_in;
    end

endmodule

// File: rtl/ldpc_qc_decoder.sv
// Partially parallel min-sum decoder for a regular QC-LDPC code.
// NC bit engines (one per block-column) and NR check engines (one per
// block-row) each sweep their P nodes serially; edge addresses come from
// the circulant shift. Assumes N LLRs are loaded before start.
module ldpc_qc_decoder
    import ldpc_pkg::*;
#(
    parameter int P      = 7,
    parameter int NC     = 5,
    parameter int NR     = 3,
    parameter int MW     = 4,
    parameter int MAX_IT = 8,
    localparam int N     = NC * P,
    localparam int IW    = $clog2(MAX_IT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          llr_valid,
    input  logic [MW-1:0] llr_in,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          converged,
    output logic [IW-1:0] iter_count,
    output logic [N-1:0]  codeword
);
    localparam int AW = (P > 1) ? $clog2(P) : 1;
    localparam int JW = (NC > 1) ? $clog2(NC) : 1;
    localparam logic [MW-1:0] MOST_NEG = {1'b1, {(MW-1){1'b0}}};

    dec_state_t    state;
    logic [AW-1:0] cnt, load_k;
    logic [JW-1:0] load_j;
    logic [IW-1:0] iter;
    logic          syn_acc, syn_now;

    logic [MW-1:0] llr_mem [NC][P];
    logic [MW-1:0] v2c_mem [NR][NC][P];
    logic [MW-1:0] c2v_mem [NR][NC][P];
    logic [P-1:0]  hard_mem [NC];

    logic [NR*MW-1:0] bpe_c2v [NC];
    logic [NR*MW-1:0] bpe_v2c [NC];
    logic [NC-1:0]    bpe_hard;
    logic [AW-1:0]    chk_addr [NR][NC];
    logic [NC*MW-1:0] cpe_v2c [NR];
    logic [NC-1:0]    cpe_hard [NR];
    logic [NC*MW-1:0] cpe_c2v [NR];
    logic [NR-1:0]    cpe_par;

    genvar gj, gi;
    generate
        for (gj = 0; gj < NC; gj++) begin : g_bpe
            // Gather this column's check messages for node cnt.
            always_comb
                for (int i = 0; i < NR; i++)
                    bpe_c2v[gj][i*MW +: MW] = c2v_mem[i][gj][cnt];
            ldpc_bpe #(.NR(NR), .MW(MW)) u_bpe (
                .llr_in (llr_mem[gj][cnt]),
                .c2v_in (bpe_c2v[gj]),
                .v2c_out(bpe_v2c[gj]),
                .hard   (bpe_hard[gj])
            );
        end
        for (gi = 0; gi < NR; gi++) begin : g_cpe
            // Compute circulant addresses and gather edges of check cnt.
            always_comb
                for (int j = 0; j < NC; j++) begin
                    chk_addr[gi][j] = AW'((int'(cnt) + P - circ_shift(gi, j, P)) % P);
                    cpe_v2c[gi][j*MW +: MW] = v2c_mem[gi][j][chk_addr[gi][j]];
                    cpe_hard[gi][j] = hard_mem[j][chk_addr[gi][j]];
                end
            ldpc_cpe #(.NC(NC), .MW(MW)) u_cpe (
                .v2c_in (cpe_v2c[gi]),
                .hard_in(cpe_hard[gi]),
                .c2v_out(cpe_c2v[gi]),
                .parity (cpe_par[gi])
            );
        end
    endgenerate

    // Edge, LLR and decision stores; writes depend on phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NC; j++) hard_mem[j] <= '0;
        end else begin
            if (state == ST_IDLE && llr_valid)
                llr_mem[load_j][load_k] <= (llr_in == MOST_NEG) ? MOST_NEG + 1'b1 : llr_in;
            if (state == ST_IDLE && start)
                for (int i = 0; i < NR; i++)
                    for (int j = 0; j < NC; j++)
                        for (int k = 0; k < P; k++) c2v_mem[i][j][k] <= '0;
            if (state == ST_BIT)
                for (int j = 0; j < NC; j++) begin
                    hard_mem[j][cnt] <= bpe_hard[j];
                    for (int i = 0; i < NR; i++)
                        v2c_mem[i][j][cnt] <= bpe_v2c[j][i*MW +: MW];
                end
            if (state == ST_CHK)
                for (int i = 0; i < NR; i++)
                    for (int j = 0; j < NC; j++)
                        c2v_mem[i][j][chk_addr[i][j]] <= cpe_c2v[i][j*MW +: MW];
        end
    end

    assign syn_now = syn_acc | (|cpe_par);

    // Phase sequencing, load pointer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; iter <= '0; syn_acc <= 1'b0;
            load_j <= '0; load_k <= '0;
            done <= 1'b0; converged <= 1'b0; iter_count <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (llr_valid) begin
                        if (load_k == AW'(P - 1)) begin
                            load_k <= '0;
                            load_j <= (load_j == JW'(NC - 1)) ? '0 : load_j + 1'b1;
                        end else load_k <= load_k + 1'b1;
                    end
                    if (start) begin
                        state <= ST_BIT; cnt <= '0; iter <= IW'(1);
                        load_j <= '0; load_k <= '0;
                        converged <= 1'b0; iter_count <= '0;
                    end
                end
                ST_BIT: begin
                    if (cnt == AW'(P - 1)) begin
                        cnt <= '0; state <= ST_CHK; syn_acc <= 1'b0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    syn_acc <= syn_now;
                    if (cnt == AW'(P - 1)) begin
                        cnt <= '0;
                        if (!syn_now || iter == IW'(MAX_IT)) begin
                            state <= ST_IDLE; done <= 1'b1;
                            converged <= !syn_now; iter_count <= iter;
                        end else begin
                            state <= ST_BIT; iter <= iter + 1'b1;
                        end
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // Flatten decisions: code bit n = column n/P, position n%P.
    always_comb
        for (int j = 0; j < NC; j++)
            for (int k = 0; k < P; k++) codeword[j*P + k] = hard_mem[j][k];

endmodule

// File: rtl/ldpc_qc_decoder_chk.sv
// Assertion checker for ldpc_qc_decoder; recomputes the syndrome of the
// output word from the circulant rule. Assumes full loads before start.
module ldpc_qc_decoder_chk
    import ldpc_pkg::*;
#(
    parameter int P      = 7,
    parameter int NC     = 5,
    parameter int NR     = 3,
    parameter int MAX_IT = 8,
    localparam int N     = NC * P,
    localparam int IW    = $clog2(MAX_IT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          converged,
    input logic [IW-1:0] iter_count,
    input logic [N-1:0]  codeword
);
    logic [NR*P-1:0] syn_vec;

    // Parity of each check over the output word.
    always_comb
        for (int i = 0; i < NR; i++)
            for (int m = 0; m < P; m++) begin
                syn_vec[i*P + m] = 1'b0;
                for (int j = 0; j < NC; j++)
                    syn_vec[i*P + m] = syn_vec[i*P + m] ^
                        codeword[j*P + ((m + P - circ_shift(i, j, P)) % P)];
            end

    // R6
    conv_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && converged |-> syn_vec == '0);
    // R6
    iter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> iter_count >= IW'(1) && iter_count <= IW'(MAX_IT));
    // R7
    max_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !converged |-> iter_count == IW'(MAX_IT));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    // R10
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(codeword) && $stable(converged));

endmodule

bind ldpc_qc_decoder ldpc_qc_decoder_chk #(.P(P), .NC(NC), .NR(NR), .MAX_IT(MAX_IT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .converged(converged), .iter_count(iter_count), .codeword(codeword)
);

// File: tb/sim_ldpc_qc_decoder.sv
module sim_ldpc_qc_decoder;
    localparam int P = 7, NC = 5, NR = 3, MW = 4, MAXI = 8;
    localparam int N = NC * P;
    localparam int IW = $clog2(MAXI + 1);
    localparam int IW1 = $clog2(1 + 1);
    localparam int NV = 7;
    localparam logic [N-1:0] V_MASK [NV] = '{35'h0, 35'h200, 35'h7_FFFF_FFFF,
        35'h0_0000_1001, 35'h0_000F_0F0F, 35'h5_5555_5555, 35'h0_3C00_0003};
    localparam int V_BAD  [NV] = '{-1, -1, -3, -2, -6, -7, -4};
    localparam int V_GOOD [NV] = '{5, 5, 5, 3, 2, 7, 3};
    localparam int ROW [3] = '{1, 3, 6};

    logic clk = 0, rst_n = 0, llr_valid = 0, start = 0;
    logic [MW-1:0] llr_in = '0;
    logic busy, done, converged, busy1, done1, conv1;
    logic [IW-1:0] iter_count;
    logic [IW1-1:0] iter1;
    logic [N-1:0] codeword, cw1;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    ldpc_qc_decoder #(.P(P), .NC(NC), .NR(NR), .MW(MW), .MAX_IT(MAXI)) u0 (
        .clk(clk), .rst_n(rst_n), .llr_valid(llr_valid), .llr_in(llr_in), .start(start),
        .busy(busy), .done(done), .converged(converged), .iter_count(iter_count), .codeword(codeword));
    ldpc_qc_decoder #(.P(P), .NC(NC), .NR(NR), .MW(MW), .MAX_IT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .llr_valid(llr_valid), .llr_in(llr_in), .start(start),
        .busy(busy1), .done(done1), .converged(conv1), .iter_count(iter1), .codeword(cw1));

    int stim [N];
    logic [N-1:0] e_cw;
    int e_conv, e_it;

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int clipv(input int x);
        return (x > 7) ? 7 : (x < -7) ? -7 : x;
    endfunction

    // Reference min-sum written from the requirements.
    task automatic model_run();
        int c2v [NR][NC][P];
        int v2c [NR][NC][P];
        bit hd [N];
        foreach (c2v[i, j, k]) c2v[i][j][k] = 0;
        e_conv = 0; e_it = MAXI;
        for (int it = 1; it <= MAXI; it++) begin
            bit syn = 0;
            for (int j = 0; j < NC; j++)
                for (int k = 0; k < P; k++) begin
                    int tot = clipv(stim[j*P+k]);
                    for (int i = 0; i < NR; i++) tot += c2v[i][j][k];
                    hd[j*P+k] = (tot < 0);
                    for (int i = 0; i < NR; i++) v2c[i][j][k] = clipv(tot - c2v[i][j][k]);
                end
            for (int i = 0; i < NR; i++)
                for (int m = 0; m < P; m++) begin
                    int ad [NC];
                    bit par = 0;
                    for (int j = 0; j < NC; j++) begin
                        ad[j] = (m - (ROW[i] * j) % P + P) % P;
                        par ^= hd[j*P + ad[j]];
                    end
                    syn |= par;
                    for (int j = 0; j < NC; j++) begin
                        int mn = 99;
                        bit ng = 0;
                        for (int o = 0; o < NC; o++) if (o != j) begin
                            int x = v2c[i][o][ad[o]];
                            if (x < 0) ng = !ng;
                            if ((x < 0 ? -x : x) < mn) mn = (x < 0 ? -x : x);
                        end
                        c2v[i][j][ad[j]] = ng ? -mn : mn;
                    end
                end
            for (int n = 0; n < N; n++) e_cw[n] = hd[n];
            if (!syn) begin e_conv = 1; e_it = it; break; end
        end
    endtask

    task automatic load_all();
        for (int n = 0; n < N; n++) begin
            @(negedge clk); llr_valid = 1; llr_in = MW'(stim[n]);
        end
        @(negedge clk); llr_valid = 0;
    endtask

    task automatic run_decode(output int cyc);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; cyc = 1;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    endtask

    task automatic check_result(input string req, input int cyc);
        check(codeword == e_cw, req, "codeword", codeword, e_cw);
        check(converged == e_conv[0], e_conv ? "R6" : "R7", "converged", converged, e_conv);
        check(int'(iter_count) == e_it, e_conv ? "R6" : "R7", "iter_count", iter_count, e_it);
        check(cyc == 2*P*e_it + 1, "R8", "latency", cyc, 2*P*e_it + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !converged, "R1", "flags", {busy, done, converged}, 0);
        check(iter_count == 0 && codeword == 0, "R1", "iter/codeword", codeword, 0);
        rst_n = 1;

        // Vector table: R2 R3 R4 R5 against the reference model.
        for (int v = 0; v < NV; v++) begin
            for (int n = 0; n < N; n++) stim[n] = V_MASK[v][n] ? V_BAD[v] : V_GOOD[v];
            load_all(); model_run(); run_decode(cyc);
            check_result("R5", cyc);
        end

        // R3 single weak error: fixed in the second iteration; MAX_IT=1 copy stops early.
        for (int n = 0; n < N; n++) stim[n] = (n == 9) ? -1 : 5;
        load_all(); run_decode(cyc);
        check(codeword == 0 && converged && iter_count == 2, "R3", "single error", iter_count, 2);
        check(cyc == 4*P + 1, "R8", "two-iteration latency", cyc, 4*P + 1);
        check(!conv1 && iter1 == 1, "R7", "limit reached", {conv1, iter1}, 1);
        check(cw1 == (N'(1) << 9), "R7", "limit word", cw1, N'(1) << 9);

        // R4 zero totals decide 0.
        for (int n = 0; n < N; n++) stim[n] = 0;
        load_all(); run_decode(cyc);
        check(codeword == 0 && converged && iter_count == 1, "R4", "zero LLR", codeword, 0);

        // R2 most-negative input clipped: all -8 behaves as all -7.
        for (int n = 0; n < N; n++) stim[n] = -8;
        load_all(); run_decode(cyc);
        check(codeword == 0 && converged && iter_count == 2, "R2", "clip -8", iter_count, 2);

        // R9 inputs while busy are ignored.
        for (int n = 0; n < N; n++) stim[n] = V_MASK[4][n] ? V_BAD[4] : V_GOOD[4];
        load_all(); model_run();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; cyc = 1;
        while (!done && cyc < 2000) begin
            llr_valid = cyc[0]; llr_in = 4'sd7; start = (cyc % 5 == 3);
            @(negedge clk); cyc++;
        end
        llr_valid = 0; start = 0;
        check_result("R9", cyc);
        run_decode(cyc);
        check(codeword == e_cw && int'(iter_count) == e_it, "R9", "rerun same LLRs", codeword, e_cw);

        // R10 results held through idle time and a new load.
        held = codeword;
        repeat (10) @(negedge clk);
        for (int n = 0; n < N; n++) stim[n] = -5;
        load_all();
        check(codeword == held, "R10", "held word", codeword, held);
        check(int'(iter_count) == e_it && converged == e_conv[0], "R10", "held status", iter_count, e_it);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule